// File: doc/BRIEF.md
# Six-Step Commutation Sequencer

This block steps a three-phase brushless DC bridge through trapezoidal commutation. In every step one phase has its high-side switch enabled for PWM, a second phase has its low-side switch conducting, and the third phase has both switches off so that it floats. The block only produces the six enable lines. The PWM carrier, speed regulation and rotor position sensing are handled elsewhere.

The enable pattern is double-buffered. A pending register holds the pattern for the next step. A single-cycle commutation pulse copies it into the active register that drives the outputs. On the same edge, the pending register is reloaded with the pattern for the step after that. A direction input chooses whether the step index counts up or down. The step index is visible on a port and always names the step whose pattern is currently pending.

Top module: `bldc_commutator`

## Requirements
- R1: While reset is asserted and after it is released, `step_o` is 1 and all six enables are 0. The outputs stay at 0 until the first commutation pulse.
- R2: Phase bit positions are A=bit 0, B=bit 1 and C=bit 2. For each step the high-side and low-side phases are: 1: A,B; 2: A,C; 3: B,C; 4: B,A; 5: C,A; 6: C,B.
- R3: When a pulse arrives with `dir_i`=0, `step_o` goes from 6 to 1 on that edge, and in every other case it increments by one.
- R4: When a pulse arrives with `dir_i`=1, `step_o` goes from 1 to 6 on that edge, and in every other case it decrements by one.
- R5: The enables and `step_o` change only on a clock edge where `commute_i` is 1. In every other cycle they hold their value.
- R6: After the first pulse, exactly one high-side bit and exactly one low-side bit are set, and they belong to different phases. The third phase has both bits at 0.
- R7: In every cycle, no phase has its high-side and low-side enables both set.
- R8: A pulse applies the pattern of the step shown on `step_o` just before that edge, whatever value `dir_i` has on that edge. A direction change therefore first affects the step pending after the pulse.
- R9: Pulses on consecutive cycles each advance exactly one step, and no pending pattern is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| commute_i | input | 1 | Commutation pulse, one cycle per event |
| dir_i | input | 1 | Step order: 0 = ascending, 1 = descending |
| step_o | output | 3 | Index (1..6) of the step whose pattern is pending |
| hs_en_o | output | 3 | High-side enables, bit 0 = phase A |
| ls_en_o | output | 3 | Low-side enables, bit 0 = phase A |

## Verification
Two things happen on one clock edge: the pending pattern moves into the active register, and the pending register is refilled from the next step index. The bench provokes both together by holding the commutation pulse high over consecutive cycles. It also flips `dir_i` in the same cycle as a pulse. After each edge it compares the outputs with the pattern that was pending before that edge and with the direction-selected index. Any dropped pattern, or any direction that is applied one step too early, shows up as a wrong step.

// File: rtl/bldc_pkg.sv
`timescale 1ns/1ps
package bldc_pkg;
  localparam int unsigned NPH    = 3;
  localparam int unsigned NSTEP  = 6;
  localparam int unsigned STEP_W = $clog2(NSTEP + 1);
  localparam int unsigned PH_W   = $clog2(NPH);

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [PH_W-1:0]   phase_t;
  typedef logic [NPH-1:0]    leg_t;

  typedef struct packed {
    leg_t hs;
    leg_t ls;
  } drive_t;

  // phase whose high side is switched in a given step
  function automatic phase_t hi_phase(step_t s);
    case (s)
      step_t'(1), step_t'(2): hi_phase = phase_t'(0);
      step_t'(3), step_t'(4): hi_phase = phase_t'(1);
      default:                hi_phase = phase_t'(2);
    endcase
  endfunction

  // phase whose low side conducts in a given step
  function automatic phase_t lo_phase(step_t s);
    case (s)
      step_t'(1), step_t'(6): lo_phase = phase_t'(1);
      step_t'(2), step_t'(3): lo_phase = phase_t'(2);
      default:                lo_phase = phase_t'(0);
    endcase
  endfunction

  function automatic drive_t make_pattern(step_t s);
    drive_t d;
    for (int p = 0; p < NPH; p++) begin
      d.hs[p] = (hi_phase(s) == phase_t'(p));
      d.ls[p] = (lo_phase(s) == phase_t'(p));
    end
    return d;
  endfunction
endpackage

// File: rtl/bldc_rst_sync.sv
`timescale 1ns/1ps
module bldc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bldc_step_ctr.sv
`timescale 1ns/1ps
module bldc_step_ctr
  import bldc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  rev,
  output step_t step_q,
  output step_t step_nxt
);
  localparam step_t FIRST = step_t'(1);
  localparam step_t LAST  = step_t'(NSTEP);

  // index that follows the current one in the selected order
  always_comb begin
    if (rev) step_nxt = (step_q == FIRST) ? LAST  : step_q - step_t'(1);
    else     step_nxt = (step_q == LAST)  ? FIRST : step_q + step_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   step_q <= FIRST;
    else if (adv) step_q <= step_nxt;
  end
endmodule

// File: rtl/bldc_pattern_dec.sv
`timescale 1ns/1ps
module bldc_pattern_dec
  import bldc_pkg::*;
(
  input  step_t  step,
  output drive_t pat
);
  phase_t hi, lo;

  assign hi = hi_phase(step);
  assign lo = lo_phase(step);

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    assign pat.hs[p] = (hi == phase_t'(p));
    assign pat.ls[p] = (lo == phase_t'(p));
  end
endmodule

// File: rtl/bldc_shadow_reg.sv
`timescale 1ns/1ps
module bldc_shadow_reg
  import bldc_pkg::*;
#(
  parameter drive_t PEND_RST = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  drive_t pend_d,
  output drive_t pend_q,
  output drive_t act_q
);
  drive_t pend_n, act_n;

  // pending moves to active and is refilled on the same edge
  always_comb begin
    pend_n = pend_q;
    act_n  = act_q;
    if (load) begin
      act_n  = pend_q;
      pend_n = pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PEND_RST;
      act_q  <= '0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
    end
  end
endmodule

// File: rtl/bldc_commutator.sv
`timescale 1ns/1ps
module bldc_commutator
  import bldc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commute_i,
  input  logic              dir_i,
  output logic [STEP_W-1:0] step_o,
  output logic [NPH-1:0]    hs_en_o,
  output logic [NPH-1:0]    ls_en_o
);
  localparam drive_t RST_PEND = make_pattern(step_t'(1));

  logic   rst_sync_n;
  step_t  step_q, step_nxt;
  drive_t pend_d, pend_q, act_q;

  bldc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bldc_step_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv      (commute_i),
    .rev      (dir_i),
    .step_q   (step_q),
    .step_nxt (step_nxt)
  );

  bldc_pattern_dec u_dec (
    .step (step_nxt),
    .pat  (pend_d)
  );

  bldc_shadow_reg #(.PEND_RST(RST_PEND)) u_buf (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (commute_i),
    .pend_d (pend_d),
    .pend_q (pend_q),
    .act_q  (act_q)
  );

  assign step_o  = step_q;
  assign hs_en_o = act_q.hs;
  assign ls_en_o = act_q.ls;
endmodule

// File: rtl/bldc_commutator_chk.sv
`timescale 1ns/1ps
module bldc_commutator_chk
  import bldc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              commute_i,
  input logic              dir_i,
  input logic [STEP_W-1:0] step_o,
  input logic [NPH-1:0]    hs_en_o,
  input logic [NPH-1:0]    ls_en_o,
  input logic [2*NPH-1:0]  pend
);
  p_no_shoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en_o & ls_en_o) == '0);

  p_one_each_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs_en_o) && ($countones(hs_en_o) == $countones(ls_en_o)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commute_i |=> $stable(hs_en_o) && $stable(ls_en_o) && $stable(step_o));

  p_fwd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commute_i && !dir_i && step_o != STEP_W'(NSTEP) |=> step_o == $past(step_o) + STEP_W'(1));

  p_fwd_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commute_i && !dir_i && step_o == STEP_W'(NSTEP) |=> step_o == STEP_W'(1));

  p_rev_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commute_i && dir_i && step_o == STEP_W'(1) |=> step_o == STEP_W'(NSTEP));

  p_apply_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commute_i |=> {hs_en_o, ls_en_o} == $past(pend));
endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .commute_i (commute_i),
  .dir_i     (dir_i),
  .step_o    (step_o),
  .hs_en_o   (hs_en_o),
  .ls_en_o   (ls_en_o),
  .pend      (pend_q)
);

// File: tb/test_bldc_commutator.sv
`timescale 1ns/1ps
module test_bldc_commutator;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       commute_i;
  logic       dir_i;
  logic [2:0] step_o, hs_en_o, ls_en_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #4 clk = ~clk;  // 125 MHz

  bldc_commutator i_bldc_commutator (
    .clk       (clk),
    .rst_n     (rst_n),
    .commute_i (commute_i),
    .dir_i     (dir_i),
    .step_o    (step_o),
    .hs_en_o   (hs_en_o),
    .ls_en_o   (ls_en_o)
  );

  // {dir, expected step after pulse, expected hs, expected ls}
  localparam logic [9:0] VEC [12] = '{
    {1'b0, 3'd2, 3'b001, 3'b010},
    {1'b0, 3'd3, 3'b001, 3'b100},
    {1'b0, 3'd4, 3'b010, 3'b100},
    {1'b0, 3'd5, 3'b010, 3'b001},
    {1'b0, 3'd6, 3'b100, 3'b001},
    {1'b0, 3'd1, 3'b100, 3'b010},
    {1'b0, 3'd2, 3'b001, 3'b010},
    {1'b1, 3'd1, 3'b001, 3'b100},
    {1'b1, 3'd6, 3'b001, 3'b010},
    {1'b1, 3'd5, 3'b100, 3'b010},
    {1'b1, 3'd4, 3'b100, 3'b001},
    {1'b0, 3'd5, 3'b010, 3'b001}
  };

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s step/hs/ls actual=%b expected=%b", req, act, exp);
    end
  endtask

  // R7: every cycle, no phase with both switches on
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      checks++;
      if ((hs_en_o & ls_en_o) !== 3'b000) begin
        failures++;
        $display("FAIL R7 overlap actual=%b expected=000", hs_en_o & ls_en_o);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    commute_i = 1'b0;
    dir_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R1", {step_o, hs_en_o, ls_en_o}, {3'd1, 6'b0});

    for (int i = 0; i < 12; i++) begin
      commute_i = 1'b1;
      dir_i = VEC[i][9];
      @(negedge clk);
      commute_i = 1'b0;
      check(VEC[i][9] ? "R4 R8" : "R2 R3", {step_o, hs_en_o, ls_en_o}, VEC[i][8:0]);
      checks++;
      if ($countones(hs_en_o) != 1 || $countones(ls_en_o) != 1) begin
        failures++;
        $display("FAIL R6 counts actual=%0d/%0d expected=1/1",
                 $countones(hs_en_o), $countones(ls_en_o));
      end
      dir_i = ~dir_i;  // direction wiggle while idle must not matter
      repeat (2) @(negedge clk);
      check("R5", {step_o, hs_en_o, ls_en_o}, VEC[i][8:0]);
    end

    // reset mid-run clears pattern and index
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async", {step_o, hs_en_o, ls_en_o}, {3'd1, 6'b0});
    do_reset();
    check("R1 hold", {step_o, hs_en_o, ls_en_o}, {3'd1, 6'b0});

    // back-to-back pulses: transfer and refill on every edge
    commute_i = 1'b1;
    dir_i = 1'b0;
    @(negedge clk);
    check("R9 a", {step_o, hs_en_o, ls_en_o}, {3'd2, 3'b001, 3'b010});
    @(negedge clk);
    check("R9 b", {step_o, hs_en_o, ls_en_o}, {3'd3, 3'b001, 3'b100});
    dir_i = 1'b1;  // flip in a pulse cycle: pending step 3 still applied
    @(negedge clk);
    check("R9 R8", {step_o, hs_en_o, ls_en_o}, {3'd2, 3'b010, 3'b100});
    commute_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 tail", {step_o, hs_en_o, ls_en_o}, {3'd2, 3'b010, 3'b100});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule